// File: doc/BRIEF.md
# Reset and Prioritized Interrupt Entry/Return Sequencer

This block walks an 8-bit processor core through its three non-instruction control flows: reset, interrupt entry and return from interrupt. It owns the 16-bit stack pointer and a byte-wide memory port with a request/acknowledge handshake. Instruction execution stays outside the block. While the block is busy, the core stalls. The core receives register loads (PC, X, A, CCR) as single-cycle strobes with data.

Any reset brings the stack pointer to 0x00FF and fetches the reset vector. Reset can come from the asynchronous pin or from any of the synchronous reset sources, and no mask applies to it. Interrupt requests are latched. A latched request is recognized only when its own enable is set, the core's interrupt mask bit is clear and the block is idle. When several are recognized at once, a fixed priority picks one. The block then pushes the processor state, sets the mask bit in the CCR load and reads the winner's vector into the PC. A return strobe pulls the saved state back in reverse order.

Top module: `irq_seq`

## Requirements
- R1: After the asynchronous reset, or after any synchronous reset source, sp_o is 0x00FF. The block then reads 0xFFFE as the PC high byte and 0xFFFF as the PC low byte, and pulses pc_load_o with the assembled value.
- R2: A synchronous reset source aborts any sequence in progress regardless of imask_i, clears all latched requests and restarts the reset vector fetch.
- R3: A one-cycle pulse on irq_req_i[n] is latched and held until that source is serviced or a reset occurs. Its enable and the mask bit affect only recognition, not latching.
- R4: A latched request n is recognized only when irq_en_i[n] is 1, imask_i is 0 and the block is idle (busy_o low). Otherwise the block makes no memory access.
- R5: Among recognized requests, the lowest index wins. The others stay latched and are serviced after later returns.
- R6: Entry pushes five bytes, one per accepted write, at addresses SP, SP-1, ..., SP-4 in the order PC[7:0], PC[15:8], X, A, CCR, using values sampled at recognition. SP decrements once per push and ends 5 lower.
- R7: One cycle after the decision to take request n, irq_ack_o pulses one-hot with bit n. After the fifth push, ccr_load_o pulses with ccr_o equal to the stacked CCR with bit 3 (the interrupt mask) set.
- R8: The vector for source n is read as its high byte at 0xFFFC - 2n and its low byte at 0xFFFD - 2n. It is then loaded with pc_load_o.
- R9: A one-cycle rti_i while idle pulls five bytes from SP+1 upward: CCR, A, X, PC high, PC low. It pulses ccr_load_o, a_load_o and x_load_o with the pulled values, then pulses pc_load_o with the restored PC. SP ends 5 higher.
- R10: Each access holds mem_rd_o or mem_wr_o with a stable address until mem_ack_i. Read and write strobes are never high together, and SP changes only on an acknowledged stack access or a reset.
- R11: busy_o is high from the first cycle of a sequence until the cycle of its final load strobe, when it is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_src_i | input | N_RST | Synchronous reset requests (pin, watchdog, illegal opcode, low voltage) |
| irq_req_i | input | N_SRC | Interrupt request pulses, index 0 highest priority |
| irq_en_i | input | N_SRC | Per-source enables |
| imask_i | input | 1 | Core interrupt mask bit (CCR bit 3) |
| rti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | 16 | Current PC to stack |
| x_i | input | 8 | Current X to stack |
| a_i | input | 8 | Current A to stack |
| ccr_i | input | 8 | Current CCR to stack |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rd_o | output | 1 | Read request |
| mem_wr_o | output | 1 | Write request |
| mem_ack_i | input | 1 | Access accepted at this edge |
| mem_rdata_i | input | 8 | Read data, valid with mem_ack_i |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | PC load value |
| pc_load_o | output | 1 | PC load strobe |
| x_o | output | 8 | X restore value |
| x_load_o | output | 1 | X load strobe |
| a_o | output | 8 | A restore value |
| a_load_o | output | 1 | A load strobe |
| ccr_o | output | 8 | CCR load value |
| ccr_load_o | output | 1 | CCR load strobe |
| irq_ack_o | output | N_SRC | One-hot pulse naming the source taken |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench targets five kinds of mistake.

- Requests that arrive while masked or disabled must wait and then be served after the mask clears. A design that drops them never fetches their vector. A design that ignores the mask pushes while the core is in a handler.
- Two requests pulsed together must be served lowest index first, and the loser must run right after the winner returns. A reversed or lossy arbiter reads the wrong vector address, and the boundary indices 0 and 7 expose an off-by-one in the vector arithmetic.
- A synchronous reset injected partway through stacking must abandon the frame and leave SP at 0x00FF. An incomplete abort leaves SP part-way down or finishes the vector fetch.
- A stalling acknowledge shows whether SP or the byte order slips when the memory is slow.
- A return checks that the pull order mirrors the push order byte for byte.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int AW = 16;
  localparam int DW = 8;

  localparam logic [AW-1:0] RST_VEC  = 16'hFFFE;
  localparam logic [AW-1:0] VEC_TOP  = 16'hFFFC;
  localparam logic [AW-1:0] SP_INIT  = 16'h00FF;
  localparam int            IMASK_BIT = 3;
  localparam int            FRAME     = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_PULL,
    ST_VHI,
    ST_VLO
  } st_e;

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (flush_i) pend_q <= '0;
    else              pend_q <= (pend_q & ~clr_i) | req_i;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  en_i,
  output logic          vld_o,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);

  logic [N-1:0] live;
  logic [N:0]   below;

  assign live     = pend_i & en_i;
  assign below[0] = 1'b0;

  // lowest index wins: a source is granted only when nothing below it is live
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign below[i+1] = below[i] | live[i];
    assign gnt_o[i]   = live[i] & ~below[i];
  end

  assign vld_o = below[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_o[i]) idx_o = idx_o | IW'(i);
    end
  end

endmodule

// File: rtl/irq_sp.sv
module irq_sp
  import irq_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          push_i,
  input  logic          pull_i,
  output logic [AW-1:0] sp_o
);

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= SP_INIT;
    else if (init_i) sp_q <= SP_INIT;
    else if (push_i) sp_q <= sp_q - AW'(1);
    else if (pull_i) sp_q <= sp_q + AW'(1);
  end

  assign sp_o = sp_q;

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int N_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_RST-1:0]  rst_src_i,
  input  logic [N_SRC-1:0]  irq_req_i,
  input  logic [N_SRC-1:0]  irq_en_i,
  input  logic              imask_i,
  input  logic              rti_i,
  input  logic [15:0]       pc_i,
  input  logic [7:0]        x_i,
  input  logic [7:0]        a_i,
  input  logic [7:0]        ccr_i,
  output logic [15:0]       mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [15:0]       sp_o,
  output logic [15:0]       pc_o,
  output logic              pc_load_o,
  output logic [7:0]        x_o,
  output logic              x_load_o,
  output logic [7:0]        a_o,
  output logic              a_load_o,
  output logic [7:0]        ccr_o,
  output logic              ccr_load_o,
  output logic [N_SRC-1:0]  irq_ack_o,
  output logic              busy_o
);

  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [2:0] LAST = 3'(FRAME - 1);

  st_e            state_q;
  logic [2:0]     idx_q;
  logic [AW-1:0]  vaddr_q;
  logic [DW-1:0]  hi_q;
  logic [15:0]    snap_pc_q;
  logic [7:0]     snap_x_q, snap_a_q, snap_ccr_q;
  logic [N_SRC-1:0] ack_q;

  logic           rst_any;
  logic [N_SRC-1:0] pend, gnt, clr;
  logic           arb_vld;
  logic [IW-1:0]  arb_idx;
  logic           take, push, pull, acc;
  logic [AW-1:0]  sp;
  logic [DW-1:0]  push_byte;
  logic [AW-1:0]  vec_addr;

  assign rst_any = |rst_src_i;

  irq_pend #(.N(N_SRC)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rst_any),
    .req_i   (irq_req_i),
    .clr_i   (clr),
    .pend_o  (pend)
  );

  irq_arb #(.N(N_SRC), .IW(IW)) u_arb (
    .pend_i (pend),
    .en_i   (irq_en_i),
    .vld_o  (arb_vld),
    .gnt_o  (gnt),
    .idx_o  (arb_idx)
  );

  assign take = (state_q == ST_IDLE) && !rst_any && !rti_i && arb_vld && !imask_i;
  assign clr  = take ? gnt : '0;
  assign acc  = mem_ack_i && !rst_any;
  assign push = (state_q == ST_PUSH) && acc;
  assign pull = (state_q == ST_PULL) && acc;

  irq_sp u_sp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (rst_any),
    .push_i (push),
    .pull_i (pull),
    .sp_o   (sp)
  );

  assign vec_addr = VEC_TOP - (AW'(arb_idx) << 1);

  always_comb begin
    unique case (idx_q)
      3'd0:    push_byte = snap_pc_q[7:0];
      3'd1:    push_byte = snap_pc_q[15:8];
      3'd2:    push_byte = snap_x_q;
      3'd3:    push_byte = snap_a_q;
      default: push_byte = snap_ccr_q;
    endcase
  end

  always_comb begin
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_PUSH: begin
        mem_wr_o    = 1'b1;
        mem_addr_o  = sp;
        mem_wdata_o = push_byte;
      end
      ST_PULL: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = sp + AW'(1);
      end
      ST_VHI: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = vaddr_q;
      end
      ST_VLO: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = vaddr_q + AW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_VHI;
      vaddr_q    <= RST_VEC;
      idx_q      <= '0;
      hi_q       <= '0;
      snap_pc_q  <= '0;
      snap_x_q   <= '0;
      snap_a_q   <= '0;
      snap_ccr_q <= '0;
      ack_q      <= '0;
      pc_o       <= '0;
      pc_load_o  <= 1'b0;
      x_o        <= '0;
      x_load_o   <= 1'b0;
      a_o        <= '0;
      a_load_o   <= 1'b0;
      ccr_o      <= '0;
      ccr_load_o <= 1'b0;
    end else begin
      pc_load_o  <= 1'b0;
      x_load_o   <= 1'b0;
      a_load_o   <= 1'b0;
      ccr_load_o <= 1'b0;
      ack_q      <= '0;
      if (rst_any) begin
        state_q <= ST_VHI;
        vaddr_q <= RST_VEC;
        idx_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            idx_q <= '0;
            if (rti_i) begin
              state_q <= ST_PULL;
            end else if (take) begin
              state_q    <= ST_PUSH;
              vaddr_q    <= vec_addr;
              ack_q      <= gnt;
              snap_pc_q  <= pc_i;
              snap_x_q   <= x_i;
              snap_a_q   <= a_i;
              snap_ccr_q <= ccr_i;
            end
          end
          ST_PUSH: if (mem_ack_i) begin
            idx_q <= idx_q + 3'd1;
            if (idx_q == LAST) begin
              idx_q      <= '0;
              state_q    <= ST_VHI;
              ccr_o      <= snap_ccr_q | 8'(1 << IMASK_BIT);
              ccr_load_o <= 1'b1;
            end
          end
          ST_PULL: if (mem_ack_i) begin
            idx_q <= idx_q + 3'd1;
            unique case (idx_q)
              3'd0: begin ccr_o <= mem_rdata_i; ccr_load_o <= 1'b1; end
              3'd1: begin a_o   <= mem_rdata_i; a_load_o   <= 1'b1; end
              3'd2: begin x_o   <= mem_rdata_i; x_load_o   <= 1'b1; end
              3'd3: hi_q <= mem_rdata_i;
              default: begin
                pc_o      <= {hi_q, mem_rdata_i};
                pc_load_o <= 1'b1;
                idx_q     <= '0;
                state_q   <= ST_IDLE;
              end
            endcase
          end
          ST_VHI: if (mem_ack_i) begin
            hi_q    <= mem_rdata_i;
            state_q <= ST_VLO;
          end
          ST_VLO: if (mem_ack_i) begin
            pc_o      <= {hi_q, mem_rdata_i};
            pc_load_o <= 1'b1;
            state_q   <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sp_o      = sp;
  assign irq_ack_o = ack_q;
  assign busy_o    = (state_q != ST_IDLE);

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int N_RST = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_RST-1:0] rst_src_i,
  input logic             imask_i,
  input logic [15:0]      mem_addr_o,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic             mem_ack_i,
  input logic [15:0]      sp_o,
  input logic [7:0]       ccr_o,
  input logic             ccr_load_o,
  input logic [N_SRC-1:0] irq_ack_o,
  input st_e              state_i
);

  // R10
  a_r10_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o}));

  // R10
  a_r10_sp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ack_i && !(|rst_src_i)) |=> $stable(sp_o));

  // R1
  a_r1_sp_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rst_src_i) |=> (sp_o == SP_INIT));

  // R6
  a_r6_push_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && mem_ack_i && !(|rst_src_i)) |=> (sp_o == $past(sp_o) - 16'd1));

  // R9
  a_r9_pull_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PULL && mem_ack_i && !(|rst_src_i)) |=> (sp_o == $past(sp_o) + 16'd1));

  // R7
  a_r7_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_ack_o) |-> $onehot(irq_ack_o));

  // R7
  a_r7_first_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_ack_o) |-> (mem_wr_o && mem_addr_o == sp_o));

  // R4
  a_r4_taken_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_ack_o) |-> $past(!imask_i));

  // R7
  a_r7_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccr_load_o && $past(state_i == ST_PUSH)) |-> ccr_o[IMASK_BIT]);

endmodule

bind irq_seq irq_seq_chk #(.N_SRC(N_SRC), .N_RST(N_RST)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_src_i  (rst_src_i),
  .imask_i    (imask_i),
  .mem_addr_o (mem_addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_ack_i  (mem_ack_i),
  .sp_o       (sp_o),
  .ccr_o      (ccr_o),
  .ccr_load_o (ccr_load_o),
  .irq_ack_o  (irq_ack_o),
  .state_i    (state_q)
);

// File: tb/sim_irq_seq.sv
`timescale 1ns/1ps
module sim_irq_seq;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rst_src = '0;
  logic [7:0]  irq_req = '0;
  logic [7:0]  irq_en = 8'hFF;
  logic        imask = 1'b1;
  logic        rti = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, a_in = '0, ccr_in = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rd, mem_wr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] sp, pc_out;
  logic        pc_load, x_load, a_load, ccr_load, busy;
  logic [7:0]  x_out, a_out, ccr_out, irq_ack;

  always #4 clk = ~clk;

  irq_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rst_src_i(rst_src), .irq_req_i(irq_req),
    .irq_en_i(irq_en), .imask_i(imask), .rti_i(rti), .pc_i(pc_in), .x_i(x_in),
    .a_i(a_in), .ccr_i(ccr_in), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .sp_o(sp), .pc_o(pc_out), .pc_load_o(pc_load), .x_o(x_out), .x_load_o(x_load),
    .a_o(a_out), .a_load_o(a_load), .ccr_o(ccr_out), .ccr_load_o(ccr_load),
    .irq_ack_o(irq_ack), .busy_o(busy)
  );

  typedef struct { bit wr; bit [15:0] addr; bit [7:0] data; } acc_t;
  acc_t acc_q[$];
  logic [7:0] mem [logic [15:0]];
  bit   slow = 0, tgl = 0;
  logic [15:0] last_pc = '0;
  logic [7:0]  last_ccr = '0, last_a = '0, last_x = '0, last_ack = '0;
  int n_chk = 0, n_fail = 0;

  function automatic logic [7:0] mrd(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  // memory and core model, reacting away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      tgl = ~tgl;
      if (rst_ni && (mem_rd || mem_wr) && (!slow || tgl)) begin
        mem_ack = 1'b1;
        if (mem_wr) begin
          mem[mem_addr] = mem_wdata;
          acc_q.push_back('{1'b1, mem_addr, mem_wdata});
        end else begin
          mem_rdata = mrd(mem_addr);
          acc_q.push_back('{1'b0, mem_addr, mem_rdata});
        end
      end else begin
        mem_ack = 1'b0;
      end
      if (pc_load) last_pc = pc_out;
      if (ccr_load) begin last_ccr = ccr_out; imask = ccr_out[3]; end
      if (a_load) last_a = a_out;
      if (x_load) last_x = x_out;
      if (|irq_ack) last_ack = irq_ack;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    repeat (3) @(negedge clk);
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  task automatic pulse_req(logic [7:0] m);
    @(negedge clk); irq_req = m;
    @(negedge clk); irq_req = '0;
  endtask

  task automatic do_rti();
    @(negedge clk); rti = 1'b1;
    @(negedge clk); rti = 1'b0;
    wait_idle();
  endtask

  function automatic int tail_addr(int k);
    return (acc_q.size() >= k) ? int'(acc_q[acc_q.size()-k].addr) : -1;
  endfunction

  function automatic logic [15:0] vec(int n);
    return {8'(8'hC0 + n), 8'(n * 16 + 1)};
  endfunction

  task automatic t_r1_reset();
    slow = 1;
    repeat (3) @(negedge clk);
    acc_q.delete();
    rst_ni = 1'b1;
    wait_idle();
    chk("R1", "reset access count", acc_q.size(), 2);
    chk("R1", "first reset read addr", tail_addr(2), 16'hFFFE);
    chk("R1", "second reset read addr", tail_addr(1), 16'hFFFF);
    chk("R1", "reset pc", last_pc, 16'h8010);
    chk("R1", "reset sp", sp, 16'h00FF);
    chk("R11", "busy low after reset fetch", busy, 0);
    slow = 0;
  endtask

  task automatic t_r6_entry();
    logic [7:0] exp_b[5] = '{8'h34, 8'h12, 8'h56, 8'h78, 8'h60};
    slow = 1;
    pc_in = 16'h1234; x_in = 8'h56; a_in = 8'h78; ccr_in = 8'h60;
    irq_en = 8'hFF; imask = 1'b0;
    acc_q.delete();
    pulse_req(8'h08);
    repeat (3) @(negedge clk);
    chk("R11", "busy during entry", busy, 1);
    pc_in = 16'hDEAD; a_in = 8'h00;
    wait_idle();
    chk("R10", "entry access count under stalls", acc_q.size(), 7);
    for (int k = 0; k < 5; k++) begin
      if (acc_q.size() > k) begin
        chk("R6", "push is write", acc_q[k].wr, 1);
        chk("R6", "push addr", acc_q[k].addr, 16'h00FF - k);
        chk("R6", "push data", acc_q[k].data, exp_b[k]);
      end
    end
    chk("R8", "vector hi addr src3", tail_addr(2), 16'hFFF6);
    chk("R8", "vector lo addr src3", tail_addr(1), 16'hFFF7);
    chk("R8", "entry pc src3", last_pc, vec(3));
    chk("R7", "ccr with mask set", last_ccr, 8'h68);
    chk("R7", "ack one-hot src3", last_ack, 8'h08);
    chk("R6", "sp after push", sp, 16'h00FA);
    slow = 0;
  endtask

  task automatic t_r9_rti();
    logic [7:0] exp_b[5] = '{8'h60, 8'h78, 8'h56, 8'h12, 8'h34};
    pc_in = 16'hFFFF; x_in = 8'hEE; a_in = 8'hEE; ccr_in = 8'hEE;
    acc_q.delete();
    do_rti();
    pc_in = 16'h0000; x_in = 8'h00; a_in = 8'h00; ccr_in = 8'h60;
    chk("R9", "pull count", acc_q.size(), 5);
    for (int k = 0; k < 5; k++) begin
      if (acc_q.size() > k) begin
        chk("R9", "pull is read", acc_q[k].wr, 0);
        chk("R9", "pull addr", acc_q[k].addr, 16'h00FB + k);
        chk("R9", "pull data", acc_q[k].data, exp_b[k]);
      end
    end
    chk("R9", "restored ccr", last_ccr, 8'h60);
    chk("R9", "restored a", last_a, 8'h78);
    chk("R9", "restored x", last_x, 8'h56);
    chk("R9", "restored pc", last_pc, 16'h1234);
    chk("R9", "sp after pull", sp, 16'h00FF);
  endtask

  task automatic t_r4_mask_priority();
    @(negedge clk); imask = 1'b1;
    acc_q.delete();
    pulse_req(8'h24);
    repeat (10) @(negedge clk);
    chk("R4", "no access while masked", acc_q.size(), 0);
    chk("R4", "idle while masked", busy, 0);
    imask = 1'b0;
    wait_idle();
    chk("R5", "winner vector addr", tail_addr(2), 16'hFFF8);
    chk("R5", "winner ack", last_ack, 8'h04);
    chk("R5", "winner pc", last_pc, vec(2));
    do_rti();
    wait_idle();
    chk("R3", "latched loser ack", last_ack, 8'h20);
    chk("R3", "latched loser vector addr", tail_addr(2), 16'hFFF2);
    chk("R3", "latched loser pc", last_pc, vec(5));
    do_rti();
    chk("R9", "sp after nested returns", sp, 16'h00FF);
  endtask

  task automatic t_r4_enable();
    irq_en = 8'hFD;
    acc_q.delete();
    pulse_req(8'h02);
    repeat (10) @(negedge clk);
    chk("R4", "no access while disabled", acc_q.size(), 0);
    irq_en = 8'hFF;
    wait_idle();
    chk("R3", "disabled request kept", last_ack, 8'h02);
    chk("R8", "vector addr src1", tail_addr(2), 16'hFFFA);
    chk("R8", "pc src1", last_pc, vec(1));
    do_rti();
  endtask

  task automatic t_r5_bounds();
    acc_q.delete();
    pulse_req(8'h81);
    wait_idle();
    chk("R5", "src0 beats src7", last_ack, 8'h01);
    chk("R8", "vector addr src0", tail_addr(2), 16'hFFFC);
    chk("R8", "pc src0", last_pc, vec(0));
    do_rti();
    wait_idle();
    chk("R5", "src7 after return", last_ack, 8'h80);
    chk("R8", "vector addr src7", tail_addr(2), 16'hFFEE);
    chk("R8", "vector lo addr src7", tail_addr(1), 16'hFFEF);
    chk("R8", "pc src7", last_pc, vec(7));
    do_rti();
    chk("R9", "sp restored", sp, 16'h00FF);
  endtask

  task automatic t_r2_sync_reset();
    int guard = 0;
    int sz;
    imask = 1'b0;
    acc_q.delete();
    pulse_req(8'h10);
    while (acc_q.size() < 2 && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    rst_src = 4'b0100; imask = 1'b1;
    @(negedge clk);
    rst_src = '0;
    wait_idle();
    chk("R2", "abort sp", sp, 16'h00FF);
    chk("R2", "abort refetch hi", tail_addr(2), 16'hFFFE);
    chk("R2", "abort refetch lo", tail_addr(1), 16'hFFFF);
    chk("R2", "abort pc", last_pc, 16'h8010);
    sz = acc_q.size();
    @(negedge clk); rst_src = 4'b0001;
    @(negedge clk); rst_src = '0;
    wait_idle();
    chk("R2", "masked reset access count", acc_q.size(), sz + 2);
    chk("R2", "masked reset fetch", tail_addr(2), 16'hFFFE);
    chk("R1", "sync reset pc", last_pc, 16'h8010);
  endtask

  initial begin
    mem[16'hFFFE] = 8'h80;
    mem[16'hFFFF] = 8'h10;
    for (int n = 0; n < 8; n++) begin
      mem[16'hFFFC - 16'(2 * n)] = vec(n)[15:8];
      mem[16'hFFFD - 16'(2 * n)] = vec(n)[7:0];
    end
    t_r1_reset();
    t_r6_entry();
    t_r9_rti();
    t_r4_mask_priority();
    t_r4_enable();
    t_r5_bounds();
    t_r2_sync_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule